// File: doc/BRIEF.md
# Bilinear Texel Cache with In-Order Return

This block is a read-only texel cache. It sits between a texture addressing stage and the next level of memory. Each request names the top-left texel (u, v) of a 2x2 bilinear footprint. The cache returns all four texels together in one response beat. Texels are held in square tiles of 8x8 texels, and one tile fills exactly one cache line, so neighbours in both u and v usually share a line. A footprint that crosses tile edges can touch up to four lines. The request becomes ready only once every line it touches is resident. Each missing line is fetched one at a time from a request/response memory port.

Responses leave through a FIFO in strict request order. A request that hits therefore waits behind an earlier request that missed. The texture path has no way to write into the cache: lines come only from memory fills. Before a texture is rendered into, a flush input drops every line at once. The storage is 4-way set-associative, with tree pseudo-LRU replacement among the valid lines of a set.

Top module: `tex_cache_2x2`

## Requirements
- R1: After reset, `req_ready_o` is 1, `resp_valid_o` is 0, `mem_req_valid_o` is 0, and no line is resident.
- R2: `resp_texels_o` carries texel (u,v) in bits [7:0], (u+1,v) in [15:8], (u,v+1) in [23:16] and (u+1,v+1) in [31:24]. Each coordinate wraps modulo 256 (COORD_W = 8).
- R3: Texel (u,v) belongs to line address {v[7:3], u[7:3]}, with the u tile index in the low 5 bits. `mem_req_addr_o` carries that address. The fill data holds texel offset o = v[2:0]*8 + u[2:0] in bits [o*8 +: 8].
- R4: Each request causes one memory fill for each distinct line of its footprint that is not resident. A footprint inside one tile costs at most one fill. A footprint at a tile corner costs up to four fills. A request whose lines are all resident costs none.
- R5: Responses come out in the order the requests were accepted. A hit never overtakes an earlier miss.
- R6: The response FIFO holds 4 entries. While `resp_ready_i` is low, at most 5 requests are accepted (4 queued and 1 held in lookup), after which `req_ready_o` stays low. A response held while not ready stays valid and unchanged.
- R7: While `flush_i` is high, no request is accepted. When no fill is in flight, a high `flush_i` invalidates every line in one cycle. During a fill, the flush waits until the fill has been installed. A line used before a flush must be fetched again after it.
- R8: The set index is {line[5], line[0]} (low bit of the v tile index, low bit of the u tile index). A fill takes the lowest invalid way of its set. When every way is valid, the fill takes the way a 3-bit tree selects. In that tree, each fill or hit by the top-left texel makes the root point away from the used pair and the leaf point away from the used way.
- R9: A memory request, once raised, stays raised with a stable address until `mem_req_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Footprint request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_u_i | input | COORD_W | Top-left texel u coordinate |
| req_v_i | input | COORD_W | Top-left texel v coordinate |
| resp_valid_o | output | 1 | Response beat available |
| resp_ready_i | input | 1 | Consumer takes the response |
| resp_texels_o | output | 4*TEXEL_W | Four texels of the footprint |
| mem_req_valid_o | output | 1 | Line fetch request |
| mem_req_ready_i | input | 1 | Memory accepts the fetch |
| mem_req_addr_o | output | 2*(COORD_W-TILE_LOG2) | Line address to fetch |
| mem_resp_valid_i | input | 1 | Fill data valid |
| mem_resp_data_i | input | 64*TEXEL_W | Whole line of texels |
| flush_i | input | 1 | Invalidate all lines |

## Verification
The bench goes after footprints that cross one, two and four tiles, including the wrap at coordinate 255. A lookup that ignored a corner's line, or did not wrap, would return a wrong texel. Counting fills per request shows whether duplicate lines are merged or fetched twice. Putting a hit behind a slow miss exposes any design that lets a hit overtake. A flush raised during a fill must both wait and still cost a second fetch; a design that dropped the flush or cleared the line being installed would show a wrong fill count. A crafted eviction sequence in one set catches a replacement tree whose pointers are inverted or never updated on hits.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int unsigned TC_WAYS    = 4;
  localparam int unsigned TC_CORNERS = 4;

  typedef enum logic [1:0] {
    TC_IDLE,
    TC_CHECK,
    TC_MREQ,
    TC_MRSP
  } tc_state_e;

  // Tree bits: [0] root (0 -> pair of ways 0/1), [1] leaf of pair 0/1, [2] leaf of pair 2/3
  function automatic logic [1:0] plru_pick(input logic [2:0] tree);
    return tree[0] ? {1'b1, tree[2]} : {1'b0, tree[1]};
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] tree, input logic [1:0] way);
    logic [2:0] nxt;
    nxt    = tree;
    nxt[0] = ~way[1];
    if (way[1]) nxt[2] = ~way[0];
    else        nxt[1] = ~way[0];
    return nxt;
  endfunction

endpackage

// File: rtl/tc_tag_array.sv
module tc_tag_array
  import tc_pkg::*;
#(
  parameter int unsigned SET_W  = 2,
  parameter int unsigned ADDR_W = 10
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [TC_CORNERS-1:0][SET_W-1:0]     lk_set_i,
  input  logic [TC_CORNERS-1:0][ADDR_W-1:0]    lk_addr_i,
  output logic [TC_CORNERS-1:0]                hit_o,
  output logic [TC_CORNERS-1:0][1:0]           hit_way_o,
  input  logic                                 touch_en_i,
  input  logic [SET_W-1:0]                     touch_set_i,
  input  logic [1:0]                           touch_way_i,
  input  logic                                 inst_en_i,
  input  logic [SET_W-1:0]                     inst_set_i,
  input  logic [ADDR_W-1:0]                    inst_addr_i,
  output logic [1:0]                           inst_way_o,
  input  logic                                 flush_en_i
);

  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0][TC_WAYS-1:0] valid_q, valid_d;
  logic [SETS-1:0][2:0]         plru_q, plru_d;
  logic [ADDR_W-1:0]            tag_q [SETS][TC_WAYS];

  // One comparator bank per footprint corner
  for (genvar p = 0; p < TC_CORNERS; p++) begin : g_lookup
    logic [TC_WAYS-1:0] match;
    logic [1:0]         enc;

    always_comb begin
      match = '0;
      enc   = '0;
      for (int w = 0; w < TC_WAYS; w++) begin
        match[w] = valid_q[lk_set_i[p]][w] && (tag_q[lk_set_i[p]][w] == lk_addr_i[p]);
        if (match[w]) enc = 2'(w);
      end
    end

    assign hit_o[p]     = |match;
    assign hit_way_o[p] = enc;

    // R4: a line is never resident in two ways of its set
    a_r4_no_dup_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(match));
  end

  // Victim: lowest invalid way, otherwise the tree choice
  always_comb begin
    logic [TC_WAYS-1:0] vset;
    vset       = valid_q[inst_set_i];
    inst_way_o = plru_pick(plru_q[inst_set_i]);
    for (int w = TC_WAYS - 1; w >= 0; w--) begin
      if (!vset[w]) inst_way_o = 2'(w);
    end
  end

  always_comb begin
    valid_d = valid_q;
    plru_d  = plru_q;
    if (flush_en_i) begin
      valid_d = '0;
    end else if (inst_en_i) begin
      valid_d[inst_set_i][inst_way_o] = 1'b1;
      plru_d[inst_set_i]              = plru_touch(plru_q[inst_set_i], inst_way_o);
    end
    if (touch_en_i) begin
      plru_d[touch_set_i] = plru_touch(plru_d[touch_set_i], touch_way_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      plru_q  <= '0;
    end else begin
      valid_q <= valid_d;
      plru_q  <= plru_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (inst_en_i) tag_q[inst_set_i][inst_way_o] <= inst_addr_i;
  end

  // R7: invalidate never coincides with an install
  a_r7_flush_not_during_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_en_i |-> !inst_en_i);

  // R7: a flush leaves the whole array empty
  a_r7_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_en_i |=> (valid_q == '0));

endmodule

// File: rtl/tc_data_array.sv
module tc_data_array
  import tc_pkg::*;
#(
  parameter int unsigned SET_W   = 2,
  parameter int unsigned OFF_W   = 6,
  parameter int unsigned TEXEL_W = 8
) (
  input  logic                                  clk_i,
  input  logic                                  wr_en_i,
  input  logic [SET_W-1:0]                      wr_set_i,
  input  logic [1:0]                            wr_way_i,
  input  logic [(1<<OFF_W)*TEXEL_W-1:0]         wr_line_i,
  input  logic [TC_CORNERS-1:0][SET_W-1:0]      rd_set_i,
  input  logic [TC_CORNERS-1:0][1:0]            rd_way_i,
  input  logic [TC_CORNERS-1:0][OFF_W-1:0]      rd_off_i,
  output logic [TC_CORNERS-1:0][TEXEL_W-1:0]    rd_texel_o
);

  localparam int unsigned LINE_BITS = (1 << OFF_W) * TEXEL_W;
  localparam int unsigned ENTRIES   = (1 << SET_W) * TC_WAYS;

  logic [LINE_BITS-1:0] line_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) line_q[{wr_set_i, wr_way_i}] <= wr_line_i;
  end

  // Four independent read ports, one per footprint corner
  for (genvar p = 0; p < TC_CORNERS; p++) begin : g_rd
    logic [LINE_BITS-1:0] sel_line;
    assign sel_line      = line_q[{rd_set_i[p], rd_way_i[p]}];
    assign rd_texel_o[p] = sel_line[rd_off_i[p]*TEXEL_W +: TEXEL_W];
  end

endmodule

// File: rtl/tc_resp_fifo.sv
module tc_resp_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic             empty_o,
  output logic [WIDTH-1:0] data_o
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = wr_q + 1'b1;
    if (pop_i)  rd_d = rd_q + 1'b1;
    if (push_i && !pop_i)      cnt_d = cnt_q + 1'b1;
    else if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/tex_cache_2x2.sv
module tex_cache_2x2
  import tc_pkg::*;
#(
  parameter int unsigned COORD_W    = 8,
  parameter int unsigned TILE_LOG2  = 3,
  parameter int unsigned TEXEL_W    = 8,
  parameter int unsigned SET_W      = 2,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   req_valid_i,
  output logic                                   req_ready_o,
  input  logic [COORD_W-1:0]                     req_u_i,
  input  logic [COORD_W-1:0]                     req_v_i,
  output logic                                   resp_valid_o,
  input  logic                                   resp_ready_i,
  output logic [4*TEXEL_W-1:0]                   resp_texels_o,
  output logic                                   mem_req_valid_o,
  input  logic                                   mem_req_ready_i,
  output logic [2*(COORD_W-TILE_LOG2)-1:0]       mem_req_addr_o,
  input  logic                                   mem_resp_valid_i,
  input  logic [(1<<(2*TILE_LOG2))*TEXEL_W-1:0]  mem_resp_data_i,
  input  logic                                   flush_i
);

  localparam int unsigned TC_W    = COORD_W - TILE_LOG2;
  localparam int unsigned LADDR_W = 2 * TC_W;
  localparam int unsigned OFF_W   = 2 * TILE_LOG2;
  localparam int unsigned RESP_W  = TC_CORNERS * TEXEL_W;
  localparam int unsigned SET_Y   = SET_W / 2;
  localparam int unsigned SET_X   = SET_W - SET_Y;

  tc_state_e state_q, state_d;
  logic [COORD_W-1:0] u_q, v_q;
  logic [LADDR_W-1:0] fill_q, miss_addr;
  logic [SET_W-1:0]   fill_set;

  logic [TC_CORNERS-1:0][COORD_W-1:0] cu, cv;
  logic [TC_CORNERS-1:0][LADDR_W-1:0] laddr;
  logic [TC_CORNERS-1:0][SET_W-1:0]   lset;
  logic [TC_CORNERS-1:0][OFF_W-1:0]   loff;
  logic [TC_CORNERS-1:0]              hit;
  logic [TC_CORNERS-1:0][1:0]         hit_way;
  logic [TC_CORNERS-1:0][TEXEL_W-1:0] rd_texel;
  logic [1:0]                         inst_way;

  logic all_hit, fifo_full, fifo_empty, push, pop, req_fire, flush_en, inst_en;

  // Footprint corners k: bit0 adds 1 to u, bit1 adds 1 to v (wrapping)
  for (genvar k = 0; k < TC_CORNERS; k++) begin : g_corner
    assign cu[k]    = u_q + COORD_W'(k & 1);
    assign cv[k]    = v_q + COORD_W'(k >> 1);
    assign laddr[k] = {cv[k][COORD_W-1:TILE_LOG2], cu[k][COORD_W-1:TILE_LOG2]};
    assign loff[k]  = {cv[k][TILE_LOG2-1:0], cu[k][TILE_LOG2-1:0]};
    if (SET_Y == 0) begin : g_setx
      assign lset[k] = laddr[k][SET_X-1:0];
    end else begin : g_setxy
      assign lset[k] = {laddr[k][TC_W +: SET_Y], laddr[k][SET_X-1:0]};
    end
  end

  if (SET_Y == 0) begin : g_fsetx
    assign fill_set = fill_q[SET_X-1:0];
  end else begin : g_fsetxy
    assign fill_set = {fill_q[TC_W +: SET_Y], fill_q[SET_X-1:0]};
  end

  // First missing corner, lowest index wins
  always_comb begin
    miss_addr = laddr[0];
    for (int k = TC_CORNERS - 1; k >= 0; k--) begin
      if (!hit[k]) miss_addr = laddr[k];
    end
  end

  assign all_hit         = &hit;
  assign push            = (state_q == TC_CHECK) && !flush_i && all_hit && !fifo_full;
  assign req_ready_o     = !flush_i && ((state_q == TC_IDLE) || push);
  assign req_fire        = req_valid_i && req_ready_o;
  assign flush_en        = flush_i && ((state_q == TC_IDLE) || (state_q == TC_CHECK));
  assign inst_en         = (state_q == TC_MRSP) && mem_resp_valid_i;
  assign mem_req_valid_o = (state_q == TC_MREQ);
  assign mem_req_addr_o  = fill_q;
  assign resp_valid_o    = !fifo_empty;
  assign pop             = resp_valid_o && resp_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TC_IDLE:  if (req_fire) state_d = TC_CHECK;
      TC_CHECK: begin
        if (!flush_i) begin
          if (!all_hit)                     state_d = TC_MREQ;
          else if (!fifo_full && !req_fire) state_d = TC_IDLE;
        end
      end
      TC_MREQ:  if (mem_req_ready_i)  state_d = TC_MRSP;
      TC_MRSP:  if (mem_resp_valid_i) state_d = TC_CHECK;
      default:  state_d = TC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TC_IDLE;
      u_q     <= '0;
      v_q     <= '0;
      fill_q  <= '0;
    end else begin
      state_q <= state_d;
      if (req_fire) begin
        u_q <= req_u_i;
        v_q <= req_v_i;
      end
      if ((state_q == TC_CHECK) && !flush_i && !all_hit) begin
        fill_q <= miss_addr;
      end
    end
  end

  tc_tag_array #(
    .SET_W  (SET_W),
    .ADDR_W (LADDR_W)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_set_i    (lset),
    .lk_addr_i   (laddr),
    .hit_o       (hit),
    .hit_way_o   (hit_way),
    .touch_en_i  (push),
    .touch_set_i (lset[0]),
    .touch_way_i (hit_way[0]),
    .inst_en_i   (inst_en),
    .inst_set_i  (fill_set),
    .inst_addr_i (fill_q),
    .inst_way_o  (inst_way),
    .flush_en_i  (flush_en)
  );

  tc_data_array #(
    .SET_W   (SET_W),
    .OFF_W   (OFF_W),
    .TEXEL_W (TEXEL_W)
  ) u_data (
    .clk_i      (clk_i),
    .wr_en_i    (inst_en),
    .wr_set_i   (fill_set),
    .wr_way_i   (inst_way),
    .wr_line_i  (mem_resp_data_i),
    .rd_set_i   (lset),
    .rd_way_i   (hit_way),
    .rd_off_i   (loff),
    .rd_texel_o (rd_texel)
  );

  tc_resp_fifo #(
    .WIDTH (RESP_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (rd_texel),
    .full_o  (fifo_full),
    .pop_i   (pop),
    .empty_o (fifo_empty),
    .data_o  (resp_texels_o)
  );

  // R9: an unaccepted line fetch holds its address
  a_r9_mreq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R6: a stalled response beat holds its data
  a_r6_resp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i |=> resp_valid_o && $stable(resp_texels_o));

  // R7: requests are refused while flush is raised
  a_r7_no_accept_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_fire);

endmodule

// File: tb/tex_cache_2x2_tb.sv
module tex_cache_2x2_tb;

  localparam int CW = 8;
  localparam int LW = 10;
  localparam int LB = 512;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          req_valid_i, req_ready_o;
  logic [CW-1:0] req_u_i, req_v_i;
  logic          resp_valid_o, resp_ready_i;
  logic [31:0]   resp_texels_o;
  logic          mem_req_valid_o, mem_req_ready_i;
  logic [LW-1:0] mem_req_addr_o;
  logic          mem_resp_valid_i;
  logic [LB-1:0] mem_resp_data_i;
  logic          flush_i;

  int n_chk = 0;
  int n_bad = 0;
  int fills = 0;
  int lat_base = 1;
  int rr_mode = 1;       // 0 random, 1 always ready, 2 stalled
  string tag = "R2";
  logic [LW-1:0] last_addr;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  tex_cache_2x2 u_dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
    .req_u_i (req_u_i), .req_v_i (req_v_i),
    .resp_valid_o (resp_valid_o), .resp_ready_i (resp_ready_i),
    .resp_texels_o (resp_texels_o),
    .mem_req_valid_o (mem_req_valid_o), .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o),
    .mem_resp_valid_i (mem_resp_valid_i), .mem_resp_data_i (mem_resp_data_i),
    .flush_i (flush_i)
  );

  function automatic logic [7:0] texel_fn(input logic [7:0] u, input logic [7:0] v);
    return 8'(u * 5 + v * 29 + 90);
  endfunction

  function automatic logic [31:0] foot_fn(input logic [7:0] u, input logic [7:0] v);
    logic [7:0] u1, v1;
    u1 = u + 8'd1;
    v1 = v + 8'd1;
    return {texel_fn(u1, v1), texel_fn(u, v1), texel_fn(u1, v), texel_fn(u, v)};
  endfunction

  function automatic logic [LB-1:0] line_fn(input logic [LW-1:0] a);
    logic [LB-1:0] d;
    for (int oy = 0; oy < 8; oy++)
      for (int ox = 0; ox < 8; ox++)
        d[(oy*8+ox)*8 +: 8] = texel_fn({a[4:0], 3'(ox)}, {a[9:5], 3'(oy)});
    return d;
  endfunction

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Next-level memory model
  bit busy = 0;
  int lat = 0;
  logic [LW-1:0] pend;
  always @(negedge clk) begin
    mem_resp_valid_i = 1'b0;
    if (busy) begin
      if (lat == 0) begin
        mem_resp_valid_i = 1'b1;
        mem_resp_data_i  = line_fn(pend);
        busy = 0;
      end else lat--;
    end
    mem_req_ready_i = !busy && !mem_resp_valid_i && ($urandom % 4 != 0);
    if (mem_req_valid_o && mem_req_ready_i) begin
      busy = 1;
      pend = mem_req_addr_o;
      last_addr = mem_req_addr_o;
      lat = lat_base + int'($urandom % 3);
      fills++;
    end
  end

  // Response consumer and in-order checker
  always @(negedge clk) begin
    resp_ready_i = (rr_mode == 1) ? 1'b1 : (rr_mode == 2) ? 1'b0 : ($urandom % 4 != 0);
    if (rst_ni && resp_valid_o && resp_ready_i) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected response", resp_texels_o, 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(resp_texels_o == foot_fn(e[15:8], e[7:0]), tag, resp_texels_o, foot_fn(e[15:8], e[7:0]));
      end
    end
  end

  task automatic send_req(input logic [7:0] u, input logic [7:0] v);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_u_i = u;
    req_v_i = v;
    #1;
    while (!req_ready_o) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back({u, v});
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic req_fills(input logic [7:0] u, input logic [7:0] v, input int exp_f, input string r);
    int f0;
    f0 = fills;
    send_req(u, v);
    drain();
    check(fills - f0 == exp_f, r, 32'(fills - f0), 32'(exp_f));
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    finish_sim();
  end

  initial begin
    int acc, f0;
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    req_u_i = '0;
    req_v_i = '0;
    flush_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(req_ready_o == 1'b1, "R1 req_ready", 32'(req_ready_o), 32'd1);
    check(resp_valid_o == 1'b0, "R1 resp_valid", 32'(resp_valid_o), 32'd0);
    check(mem_req_valid_o == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid_o), 32'd0);

    // R3 layout and address, R4 single tile fill
    tag = "R3";
    req_fills(8'd9, 8'd17, 1, "R4 one tile");
    check(last_addr == 10'h041, "R3 line address", 32'(last_addr), 32'h041);
    req_fills(8'd9, 8'd17, 0, "R4 resident hit");
    // R4 corner footprint spans four lines
    req_fills(8'd7, 8'd7, 4, "R4 corner");
    // R2 wrap at 255: tile (0,0) already resident
    tag = "R2";
    req_fills(8'd255, 8'd255, 3, "R2 wrap");

    // R5 hit queued behind slow miss
    tag = "R5";
    lat_base = 8;
    f0 = fills;
    send_req(8'd100, 8'd100);
    send_req(8'd7, 8'd7);
    drain();
    check(fills - f0 == 1, "R5 fills", 32'(fills - f0), 32'd1);
    lat_base = 1;

    // R6 backpressure
    tag = "R6";
    rr_mode = 2;
    acc = 0;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_u_i = 8'd7;
    req_v_i = 8'd7;
    repeat (20) begin
      #1;
      if (req_ready_o) begin
        acc++;
        exp_q.push_back({8'd7, 8'd7});
      end
      @(negedge clk);
    end
    req_valid_i = 1'b0;
    #1;
    check(acc == 5, "R6 accepted count", 32'(acc), 32'd5);
    check(req_ready_o == 1'b0, "R6 ready low when full", 32'(req_ready_o), 32'd0);
    check(resp_valid_o == 1'b1, "R6 response held", 32'(resp_valid_o), 32'd1);
    rr_mode = 0;
    drain();
    rr_mode = 1;

    // R7 flush while idle
    tag = "R7";
    @(negedge clk);
    flush_i = 1'b1;
    #1;
    check(req_ready_o == 1'b0, "R7 ready low on flush", 32'(req_ready_o), 32'd0);
    @(negedge clk);
    flush_i = 1'b0;
    req_fills(8'd9, 8'd17, 1, "R7 refetch after flush");

    // R7 flush raised during a fill waits, then forces a second fetch
    lat_base = 8;
    f0 = fills;
    send_req(8'd200, 8'd40);
    while (!(mem_req_valid_o || busy)) @(negedge clk);
    flush_i = 1'b1;
    #1;
    while (!mem_resp_valid_i) begin
      @(negedge clk);
      #1;
    end
    repeat (3) @(negedge clk);
    flush_i = 1'b0;
    drain();
    check(fills - f0 == 2, "R7 flush during fill", 32'(fills - f0), 32'd2);
    lat_base = 1;

    // R8 replacement within set 0: tiles (0,0),(2,0),(4,0),(6,0),(8,0)
    tag = "R8";
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    req_fills(8'd2,  8'd2, 1, "R8 fill A");
    req_fills(8'd18, 8'd2, 1, "R8 fill B");
    req_fills(8'd34, 8'd2, 1, "R8 fill C");
    req_fills(8'd50, 8'd2, 1, "R8 fill D");
    req_fills(8'd2,  8'd2, 0, "R8 hit A");
    req_fills(8'd66, 8'd2, 1, "R8 fill E evicts C");
    req_fills(8'd2,  8'd2, 0, "R8 A kept");
    req_fills(8'd18, 8'd2, 0, "R8 B kept");
    req_fills(8'd50, 8'd2, 0, "R8 D kept");
    req_fills(8'd34, 8'd2, 1, "R8 C evicted");
    req_fills(8'd2,  8'd2, 1, "R8 A evicted by C");

    // Random footprints in a small window, random handshakes (R2 R5)
    tag = "R2 R5 random";
    rr_mode = 0;
    lat_base = 0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      send_req(8'($urandom % 48), 8'($urandom % 48));
    end
    drain();
    check(exp_q.size() == 0, "R5 all returned", 32'(exp_q.size()), 32'd0);

    finish_sim();
  end

endmodule